// File: doc/BRIEF.md
# Burst-Acknowledged Download Sender

This block is the transmitting end of a link-level download session that moves a large object, split into N numbered packets, to a remote target. When started, it first sends a control frame that states N. It then waits for the target to reply with P, the number of packets the target can take between two acknowledgements. From then on it asks a local data source for packets in bursts of up to P. Each request carries a one-based packet index. After each burst it waits for the target to answer.

A positive answer after the final packet closes the session with a one-cycle done pulse. A positive answer at any other point starts the next burst. A negative answer rewinds the whole transfer to packet one and keeps the same burst size. A zero burst size aborts the session. Silence from the peer for a configurable number of cycles while a reply is due also aborts it. After an abort the machine is idle and waits for the next start.

The data source sees a request/accept pair. The index stays put until the source accepts it, so a slow source simply stretches the burst.

Top module: `bsnd_sender`

## Requirements
- R1: After a synchronous reset the block is idle: `busy_o`, `done_o`, `abort_o`, `ctl_valid_o` and `pkt_req_o` are all low.
- R2: A `start_i` pulse seen while idle with `total_pkts_i` ≥ 1 raises `ctl_valid_o` for exactly one cycle, in the cycle after the start, with `ctl_count_o` equal to that count.
- R3: No packet is requested after the count announcement until a frame of kind 2'b10 (burst size) arrives.
- R4: Packets are requested in bursts. Each burst holds P packets, or the packets still outstanding if fewer remain. Indices run 1, 2, … N in order, and each burst starts where the previous one ended.
- R5: After the last packet of a burst is accepted, `pkt_req_o` stays low until a frame of kind 2'b00 (positive acknowledge) arrives.
- R6: A positive acknowledge received after packet N has been accepted gives a one-cycle `done_o` pulse in the next cycle, and `busy_o` drops.
- R7: A frame of kind 2'b01 (negative acknowledge) received while awaiting an acknowledge restarts the transfer at index 1 with the same P.
- R8: A burst-size frame carrying zero gives a one-cycle `abort_o` pulse in the next cycle and returns the block to idle.
- R9: If the block spends TMO_CYC consecutive cycles awaiting a burst size or an acknowledge without accepting a frame, `abort_o` pulses in the following cycle and the block goes idle.
- R10: A frame whose kind is not expected in the current state is ignored. This covers kinds 2'b00, 2'b01 and 2'b11 while awaiting the burst size, and any frame while packets are being requested.
- R11: While `pkt_req_o` is high and `pkt_ack_i` is low, the request and `pkt_idx_o` hold their values into the next cycle.
- R12: A start with `total_pkts_i` equal to zero produces no announcement and gives a one-cycle `abort_o` pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a session (sampled while idle) |
| total_pkts_i | input | CNT_W | Total packet count N for the session |
| busy_o | output | 1 | Session in progress |
| done_o | output | 1 | One-cycle pulse: transfer completed and acknowledged |
| abort_o | output | 1 | One-cycle pulse: session abandoned |
| ctl_valid_o | output | 1 | Count announcement frame valid |
| ctl_count_o | output | CNT_W | Announced packet count |
| rx_valid_i | input | 1 | Received frame valid |
| rx_kind_i | input | 2 | 00 acknowledge, 01 negative acknowledge, 10 burst size, 11 reserved |
| rx_data_i | input | CNT_W | Burst size P carried by a kind-10 frame |
| pkt_req_o | output | 1 | Request for a packet from the data source |
| pkt_idx_o | output | CNT_W | One-based index of the requested packet |
| pkt_ack_i | input | 1 | Data source accepts the requested packet |

## Verification
The bench aims at the final burst when N is not a multiple of P. A design that always sends full bursts would request indices past N, and one that misses the short tail would hang waiting. It sends a negative acknowledge in the middle of a transfer. A design that rewinds only the current burst would restart at the wrong index. It also sends acknowledges and reserved frames at the wrong time, and stalls the source while a frame arrives; a design that honours those frames would end a burst early or start sending before it knows P. The timeout is measured to the exact cycle in both wait states, and a zero burst size and a zero packet count are both driven, so an off-by-one timer or a missing error path shows up as a wrong or missing abort pulse.

// File: rtl/bsnd_pkg.sv
package bsnd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ANNOUNCE,
        ST_WAIT_SIZE,
        ST_SEND,
        ST_WAIT_ACK
    } snd_state_e;

    typedef enum logic [1:0] {
        RX_ACK  = 2'b00,
        RX_NACK = 2'b01,
        RX_SIZE = 2'b10,
        RX_RSVD = 2'b11
    } rx_kind_e;

    typedef struct packed {
        logic is_ack;
        logic is_nack;
        logic is_size;
    } rx_decode_t;

    function automatic rx_decode_t decode_rx(input logic vld, input logic [1:0] kind);
        rx_decode_t d;
        d.is_ack  = vld && (kind == RX_ACK);
        d.is_nack = vld && (kind == RX_NACK);
        d.is_size = vld && (kind == RX_SIZE);
        return d;
    endfunction

endpackage

// File: rtl/bsnd_timeout.sv
module bsnd_timeout #(
    parameter int TMO_CYC = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic reload,
    output logic expired
);
    localparam int W = $clog2(TMO_CYC + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run || reload) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    // fires in the last cycle of the allowed silent window
    assign expired = run && !reload && (cnt_q == W'(TMO_CYC - 1));

endmodule

// File: rtl/bsnd_progress.sv
module bsnd_progress #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic [CNT_W-1:0] n_in,
    input  logic             load_p,
    input  logic [CNT_W-1:0] p_in,
    input  logic             restart,
    input  logic             new_burst,
    input  logic             advance,
    output logic [CNT_W-1:0] n_out,
    output logic [CNT_W-1:0] next_idx,
    output logic             last_of_burst,
    output logic             all_sent
);
    logic [CNT_W-1:0] n_q;
    logic [CNT_W-1:0] p_q;
    logic [CNT_W-1:0] sent_q;
    logic [CNT_W-1:0] inb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            n_q    <= '0;
            p_q    <= '0;
            sent_q <= '0;
            inb_q  <= '0;
        end else begin
            if (load_n) n_q <= n_in;
            if (load_p) p_q <= p_in;
            if (restart) begin
                sent_q <= '0;
                inb_q  <= '0;
            end else if (new_burst) begin
                inb_q <= '0;
            end else if (advance) begin
                sent_q <= sent_q + CNT_W'(1);
                inb_q  <= inb_q + CNT_W'(1);
            end
        end
    end

    assign n_out         = n_q;
    assign next_idx      = sent_q + CNT_W'(1);
    assign last_of_burst = ((inb_q + CNT_W'(1)) == p_q) || ((sent_q + CNT_W'(1)) == n_q);
    assign all_sent      = (sent_q == n_q);

endmodule

// File: rtl/bsnd_sender.sv
module bsnd_sender
    import bsnd_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int TMO_CYC = 100000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] total_pkts_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             abort_o,
    output logic             ctl_valid_o,
    output logic [CNT_W-1:0] ctl_count_o,
    input  logic             rx_valid_i,
    input  logic [1:0]       rx_kind_i,
    input  logic [CNT_W-1:0] rx_data_i,
    output logic             pkt_req_o,
    output logic [CNT_W-1:0] pkt_idx_o,
    input  logic             pkt_ack_i
);
    snd_state_e st_q, st_d;
    rx_decode_t rxd;
    logic done_d, abort_d;
    logic load_n, load_p, restart, new_burst, advance;
    logic last_of_burst, all_sent;
    logic in_wait, frame_take, tmo_exp;
    logic [CNT_W-1:0] n_cur, nxt_idx;

    assign rxd     = decode_rx(rx_valid_i, rx_kind_i);
    assign in_wait = (st_q == ST_WAIT_SIZE) || (st_q == ST_WAIT_ACK);
    assign frame_take = ((st_q == ST_WAIT_SIZE) && rxd.is_size) ||
                        ((st_q == ST_WAIT_ACK) && (rxd.is_ack || rxd.is_nack));

    bsnd_timeout #(.TMO_CYC(TMO_CYC)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .run     (in_wait),
        .reload  (frame_take),
        .expired (tmo_exp)
    );

    bsnd_progress #(.CNT_W(CNT_W)) u_prog (
        .clk           (clk),
        .rst           (rst),
        .load_n        (load_n),
        .n_in          (total_pkts_i),
        .load_p        (load_p),
        .p_in          (rx_data_i),
        .restart       (restart),
        .new_burst     (new_burst),
        .advance       (advance),
        .n_out         (n_cur),
        .next_idx      (nxt_idx),
        .last_of_burst (last_of_burst),
        .all_sent      (all_sent)
    );

    always_comb begin
        st_d      = st_q;
        done_d    = 1'b0;
        abort_d   = 1'b0;
        load_n    = 1'b0;
        load_p    = 1'b0;
        restart   = 1'b0;
        new_burst = 1'b0;
        advance   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (total_pkts_i == '0) begin
                        abort_d = 1'b1;
                    end else begin
                        load_n = 1'b1;
                        st_d   = ST_ANNOUNCE;
                    end
                end
            end
            ST_ANNOUNCE: st_d = ST_WAIT_SIZE;
            ST_WAIT_SIZE: begin
                if (rxd.is_size) begin
                    if (rx_data_i == '0) begin
                        abort_d = 1'b1;
                        st_d    = ST_IDLE;
                    end else begin
                        load_p  = 1'b1;
                        restart = 1'b1;
                        st_d    = ST_SEND;
                    end
                end else if (tmo_exp) begin
                    abort_d = 1'b1;
                    st_d    = ST_IDLE;
                end
            end
            ST_SEND: begin
                if (pkt_ack_i) begin
                    advance = 1'b1;
                    if (last_of_burst) st_d = ST_WAIT_ACK;
                end
            end
            ST_WAIT_ACK: begin
                if (rxd.is_ack) begin
                    if (all_sent) begin
                        done_d = 1'b1;
                        st_d   = ST_IDLE;
                    end else begin
                        new_burst = 1'b1;
                        st_d      = ST_SEND;
                    end
                end else if (rxd.is_nack) begin
                    restart = 1'b1;
                    st_d    = ST_SEND;
                end else if (tmo_exp) begin
                    abort_d = 1'b1;
                    st_d    = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            done_o  <= 1'b0;
            abort_o <= 1'b0;
        end else begin
            st_q    <= st_d;
            done_o  <= done_d;
            abort_o <= abort_d;
        end
    end

    assign busy_o      = (st_q != ST_IDLE);
    assign ctl_valid_o = (st_q == ST_ANNOUNCE);
    assign ctl_count_o = n_cur;
    assign pkt_req_o   = (st_q == ST_SEND);
    assign pkt_idx_o   = nxt_idx;

endmodule

// File: rtl/bsnd_sender_chk.sv
module bsnd_sender_chk #(
    parameter int CNT_W   = 16,
    parameter int TMO_CYC = 100000
) (
    input logic             clk,
    input logic             rst,
    input logic             busy_o,
    input logic             done_o,
    input logic             abort_o,
    input logic             ctl_valid_o,
    input logic [CNT_W-1:0] ctl_count_o,
    input logic             rx_valid_i,
    input logic             pkt_req_o,
    input logic [CNT_W-1:0] pkt_idx_o,
    input logic             pkt_ack_i
);
    localparam int SW = $clog2(TMO_CYC + 2);

    logic [SW-1:0]    silent_q;
    logic [CNT_W-1:0] n_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            silent_q <= '0;
            n_seen_q <= '0;
        end else begin
            if (ctl_valid_o) n_seen_q <= ctl_count_o;
            if (busy_o && !pkt_req_o && !ctl_valid_o && !rx_valid_i) begin
                silent_q <= silent_q + SW'(1);
            end else begin
                silent_q <= '0;
            end
        end
    end

    p_idle_no_req_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!pkt_req_o && !ctl_valid_o));

    p_announce_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        ctl_valid_o |=> !ctl_valid_o);

    p_idx_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        pkt_req_o |-> (pkt_idx_o != '0) && (pkt_idx_o <= n_seen_q));

    p_idx_step_r4: assert property (@(posedge clk) disable iff (rst)
        (pkt_req_o && pkt_ack_i) |=> (!pkt_req_o || (pkt_idx_o == $past(pkt_idx_o) + CNT_W'(1))));

    p_end_pulses_r6: assert property (@(posedge clk) disable iff (rst)
        (done_o || abort_o) |-> (!busy_o && !(done_o && abort_o)));

    p_timeout_bound_r9: assert property (@(posedge clk) disable iff (rst)
        silent_q <= SW'(TMO_CYC));

    p_hold_on_stall_r11: assert property (@(posedge clk) disable iff (rst)
        (pkt_req_o && !pkt_ack_i) |=> (pkt_req_o && $stable(pkt_idx_o)));

endmodule

bind bsnd_sender bsnd_sender_chk #(.CNT_W(CNT_W), .TMO_CYC(TMO_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .abort_o     (abort_o),
    .ctl_valid_o (ctl_valid_o),
    .ctl_count_o (ctl_count_o),
    .rx_valid_i  (rx_valid_i),
    .pkt_req_o   (pkt_req_o),
    .pkt_idx_o   (pkt_idx_o),
    .pkt_ack_i   (pkt_ack_i)
);

// File: tb/tb_bsnd_sender.sv
module tb_bsnd_sender;
    import bsnd_pkg::*;

    localparam int CNT_W = 16;
    localparam int TMO   = 20;
    localparam int NVEC  = 6;
    localparam int VEC_N [NVEC] = '{7, 6, 1, 5, 4, 10};
    localparam int VEC_P [NVEC] = '{3, 3, 1, 8, 1, 4};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] total_pkts_i = '0;
    logic             busy_o, done_o, abort_o, ctl_valid_o, pkt_req_o;
    logic [CNT_W-1:0] ctl_count_o, pkt_idx_o;
    logic             rx_valid_i = 1'b0;
    logic [1:0]       rx_kind_i = 2'b00;
    logic [CNT_W-1:0] rx_data_i = '0;
    logic             pkt_ack_i = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bsnd_sender #(.CNT_W(CNT_W), .TMO_CYC(TMO)) dut (
        .clk (clk), .rst (rst), .start_i (start_i), .total_pkts_i (total_pkts_i),
        .busy_o (busy_o), .done_o (done_o), .abort_o (abort_o),
        .ctl_valid_o (ctl_valid_o), .ctl_count_o (ctl_count_o),
        .rx_valid_i (rx_valid_i), .rx_kind_i (rx_kind_i), .rx_data_i (rx_data_i),
        .pkt_req_o (pkt_req_o), .pkt_idx_o (pkt_idx_o), .pkt_ack_i (pkt_ack_i)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic start_with(input int n);
        total_pkts_i = CNT_W'(n);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk_eq("R2 announce valid", int'(ctl_valid_o), 1);
        chk_eq("R2 announce count", int'(ctl_count_o), n);
    endtask

    task automatic send_rx(input logic [1:0] kind, input int data);
        rx_valid_i = 1'b1;
        rx_kind_i  = kind;
        rx_data_i  = CNT_W'(data);
        @(negedge clk);
        rx_valid_i = 1'b0;
        rx_kind_i  = 2'b00;
        rx_data_i  = '0;
    endtask

    task automatic expect_burst(input int exp_len, input int exp_first);
        int len = 0;
        int first = 0;
        int seq_ok = 1;
        int guard = 0;
        while (pkt_req_o && guard < 1000) begin
            if (len == 0) first = int'(pkt_idx_o);
            else if (int'(pkt_idx_o) != first + len) seq_ok = 0;
            if (pkt_ack_i) len++;
            @(negedge clk);
            guard++;
        end
        chk_eq("R4 burst length", len, exp_len);
        chk_eq("R4 burst first index", first, exp_first);
        chk_eq("R4 consecutive indices", seq_ok, 1);
        for (int k = 0; k < 2; k++) begin
            chk_eq("R5 no request before acknowledge", int'(pkt_req_o), 0);
            chk_eq("R5 still busy", int'(busy_o), 1);
            @(negedge clk);
        end
    endtask

    task automatic run_session(input int n, input int p);
        int rem;
        int idx;
        int want;
        start_with(n);
        @(negedge clk);
        chk_eq("R3 no request before size", int'(pkt_req_o), 0);
        send_rx(RX_SIZE, p);
        rem = n;
        idx = 1;
        while (rem > 0) begin
            want = (rem < p) ? rem : p;
            expect_burst(want, idx);
            rem -= want;
            idx += want;
            send_rx(RX_ACK, 0);
            if (rem > 0) chk_eq("R6 no early done", int'(done_o), 0);
        end
        chk_eq("R6 done pulse", int'(done_o), 1);
        chk_eq("R6 idle after done", int'(busy_o), 0);
        @(negedge clk);
        chk_eq("R6 done is one cycle", int'(done_o), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 50000, 0);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk_eq("R1 busy", int'(busy_o), 0);
        chk_eq("R1 done", int'(done_o), 0);
        chk_eq("R1 abort", int'(abort_o), 0);
        chk_eq("R1 ctl_valid", int'(ctl_valid_o), 0);
        chk_eq("R1 pkt_req", int'(pkt_req_o), 0);

        // vector table: full sessions, R2 R3 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            run_session(VEC_N[v], VEC_P[v]);
        end

        // R10 wrong-kind frames while awaiting size, then R7 negative acknowledge
        start_with(5);
        @(negedge clk);
        send_rx(RX_ACK, 0);
        chk_eq("R10 ack ignored awaiting size", int'(pkt_req_o), 0);
        chk_eq("R10 still busy", int'(busy_o), 1);
        send_rx(RX_NACK, 0);
        send_rx(RX_RSVD, 3);
        chk_eq("R10 nack and reserved ignored", int'(pkt_req_o), 0);
        send_rx(RX_SIZE, 2);
        expect_burst(2, 1);
        send_rx(RX_ACK, 0);
        expect_burst(2, 3);
        send_rx(RX_NACK, 0);
        chk_eq("R7 restart index", int'(pkt_idx_o), 1);
        expect_burst(2, 1);
        send_rx(RX_ACK, 0);
        expect_burst(2, 3);
        send_rx(RX_ACK, 0);
        expect_burst(1, 5);
        send_rx(RX_ACK, 0);
        chk_eq("R6 done after restart", int'(done_o), 1);
        @(negedge clk);

        // R11 stalled source, R10 frame during requests
        start_with(3);
        @(negedge clk);
        pkt_ack_i = 1'b0;
        send_rx(RX_SIZE, 3);
        chk_eq("R11 request raised", int'(pkt_req_o), 1);
        chk_eq("R11 index", int'(pkt_idx_o), 1);
        send_rx(RX_ACK, 0);
        chk_eq("R11 request held", int'(pkt_req_o), 1);
        chk_eq("R11 index held", int'(pkt_idx_o), 1);
        @(negedge clk);
        chk_eq("R11 index still held", int'(pkt_idx_o), 1);
        pkt_ack_i = 1'b1;
        expect_burst(3, 1);
        send_rx(RX_ACK, 0);
        chk_eq("R10 burst not cut by ack while sending", int'(done_o), 1);
        @(negedge clk);

        // R8 zero burst size
        start_with(4);
        @(negedge clk);
        send_rx(RX_SIZE, 0);
        chk_eq("R8 abort pulse", int'(abort_o), 1);
        chk_eq("R8 idle", int'(busy_o), 0);
        @(negedge clk);
        chk_eq("R8 abort one cycle", int'(abort_o), 0);

        // R9 timeout awaiting size
        start_with(4);
        for (int k = 1; k <= TMO; k++) begin
            @(negedge clk);
        end
        chk_eq("R9 no abort before window ends", int'(abort_o), 0);
        @(negedge clk);
        chk_eq("R9 abort awaiting size", int'(abort_o), 1);
        chk_eq("R9 idle after timeout", int'(busy_o), 0);
        @(negedge clk);

        // R9 timeout awaiting acknowledge
        start_with(4);
        @(negedge clk);
        send_rx(RX_SIZE, 2);
        while (pkt_req_o) @(negedge clk);
        for (int k = 2; k <= TMO; k++) begin
            @(negedge clk);
        end
        chk_eq("R9 no abort before ack window ends", int'(abort_o), 0);
        @(negedge clk);
        chk_eq("R9 abort awaiting ack", int'(abort_o), 1);
        chk_eq("R9 idle after ack timeout", int'(busy_o), 0);
        @(negedge clk);

        // R12 zero packet count
        total_pkts_i = '0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk_eq("R12 no announce", int'(ctl_valid_o), 0);
        chk_eq("R12 abort pulse", int'(abort_o), 1);
        chk_eq("R12 idle", int'(busy_o), 0);
        @(negedge clk);

        // machine usable again after aborts
        run_session(3, 2);

        report();
    end

endmodule